// File: doc/BRIEF.md
# Four-Bit Function-Select ALU Slice

This block is a four-bit arithmetic and logic slice whose combinational core is followed by one bank of output registers. A four-bit function code and a mode bit pick one of 32 operations on two operands. In logic mode every result bit depends only on the operand bits at the same position, and the carry path does not touch the result. In arithmetic mode a carry look-ahead network supplies the carry into every bit, so the result is a sum modulo 16.

Carries use an active-low convention at the edge of the slice. The carry input, the carry output, and the group generate and group propagate outputs are all low when asserted. Wider words are built in either of two ways. The carry output of one slice can drive the carry input of the next, or the group generate and group propagate outputs can feed an external look-ahead unit, because neither of them depends on the carry input. An all-ones flag reports when every result bit is high. In the subtract-less-one function with no incoming carry, this flag marks equal operands.

All outputs are registered. They show the function of the inputs sampled at the previous rising clock edge. A synchronous, active-high reset puts the outputs in a neutral state.

Top module: `fsel_alu_slice`

## Requirements
- R1: While `rst` is high at a rising edge, the next outputs are `res_o`=0, `cout_n_o`=1, `grp_prop_n_o`=1, `grp_gen_n_o`=1 and `all_ones_o`=0. Outside reset, every output shows the function of the inputs sampled at the previous rising edge, and it does not change before that edge.
- R2: Per bit, define the propagate term `pt = A | (B & S[0]) | (~B & S[1])`, the generate term `gt = (A & ~B & S[2]) | (A & B & S[3])`, and the half term `ht = pt & ~gt`. With `logic_mode_i`=1, each result bit is `~ht`. This gives 16 distinct bitwise functions. Among them, S=0011 gives all zeros, S=1100 gives all ones, S=1111 passes A, S=1010 passes B, S=0110 gives A XOR B, and S=1001 gives A XNOR B.
- R3: In logic mode, `cin_n_i` has no effect on `res_o`. The mode bit has no effect on `cout_n_o`, `grp_prop_n_o` or `grp_gen_n_o`.
- R4: With `logic_mode_i`=0, the result equals (the vector of `pt`) + (the vector of `gt`) + (1 if `cin_n_i`=0), modulo 16. With `cin_n_i`=1, this gives: S=1001 A plus B, S=0110 A minus B minus 1, S=0000 A, S=1111 A minus 1, and S=1100 A plus A. With `cin_n_i`=0 the result is one larger, so S=0110 gives A minus B.
- R5: `cout_n_o` is low exactly when the five-bit sum of the `pt` vector, the `gt` vector and the incoming carry reaches 16.
- R6: `grp_gen_n_o` is low exactly when the `pt` vector plus the `gt` vector reaches 16 with no incoming carry. `grp_prop_n_o` is low exactly when all four `pt` terms are 1. Neither output depends on `cin_n_i`.
- R7: `all_ones_o` is high exactly when all four result bits are high. With S=0110, arithmetic mode and `cin_n_i`=1, this happens exactly when A equals B.
- R8: `cout_n_o` equals `grp_gen_n_o & (grp_prop_n_o | cin_n_i)`, where `cin_n_i` is the value for the same operation.
- R9: Two operations run in sequence, with the low nibbles first and the carry output of that operation fed back as the carry input of the high nibbles, give the correct eight-bit sum or difference and the correct eight-bit carry out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| opa_i | input | W | Operand A |
| opb_i | input | W | Operand B |
| fsel_i | input | 4 | Function select code |
| logic_mode_i | input | 1 | 1 = bitwise logic, 0 = arithmetic |
| cin_n_i | input | 1 | Carry input, active low |
| res_o | output | W | Registered result |
| cout_n_o | output | 1 | Carry out of the top bit, active low |
| grp_prop_n_o | output | 1 | Group propagate, active low, independent of carry input |
| grp_gen_n_o | output | 1 | Group generate, active low, independent of carry input |
| all_ones_o | output | 1 | High when every result bit is high |

## Verification
Two functions can meet on the same inputs. The all-ones equality flag and the ripple carry output both come from the subtract-less-one function. Their joint value tells A<B, A=B and A>B apart. The full sweep drives that function with equal, larger and smaller operands and with both carry-input values. The flag and the carry output are then judged together against a reference built from the function table, not from the per-bit terms. In the same cycle the bench checks that the carry output agrees with the group generate and propagate outputs combined with the carry input.

// File: rtl/fsel_alu_pkg.sv
package fsel_alu_pkg;

  typedef logic [3:0] fsel_t;

  // Function codes that the checker and the block's users refer to by name
  localparam fsel_t FSEL_ARITH_ADD    = 4'b1001;
  localparam fsel_t FSEL_ARITH_SUBM1  = 4'b0110;
  localparam fsel_t FSEL_LOGIC_ZERO   = 4'b0011;
  localparam fsel_t FSEL_LOGIC_ONES   = 4'b1100;
  localparam fsel_t FSEL_LOGIC_PASS_A = 4'b1111;

endpackage

// File: rtl/alu_bit_terms.sv
module alu_bit_terms
  import fsel_alu_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  fsel_t        fsel,
  output logic [W-1:0] prop,
  output logic [W-1:0] gen,
  output logic [W-1:0] half
);

  // Each bit forms its own propagate and generate pair. Generate implies
  // propagate, so propagate-and-not-generate is the half-sum bit.
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign prop[i] = opa[i] | (opb[i] & fsel[0]) | (~opb[i] & fsel[1]);
    assign gen[i]  = (opa[i] & ~opb[i] & fsel[2]) | (opa[i] & opb[i] & fsel[3]);
    assign half[i] = prop[i] & ~gen[i];
  end

endmodule

// File: rtl/alu_carry_la.sv
module alu_carry_la #(
  parameter int W = 4
) (
  input  logic [W-1:0] prop,
  input  logic [W-1:0] gen,
  input  logic         cin,
  output logic [W:0]   carry,
  output logic         grp_prop,
  output logic         grp_gen
);

  // Generate of the span [0..hi], formed without reference to cin
  function automatic logic span_gen(input logic [W-1:0] g,
                                    input logic [W-1:0] p,
                                    input int           hi);
    logic acc;
    acc = 1'b0;
    for (int j = 0; j <= hi; j++) acc = g[j] | (p[j] & acc);
    return acc;
  endfunction

  function automatic logic span_prop(input logic [W-1:0] p, input int hi);
    logic acc;
    acc = 1'b1;
    for (int j = 0; j <= hi; j++) acc = acc & p[j];
    return acc;
  endfunction

  assign carry[0] = cin;

  // Every carry is a flat two-level term of the span terms and cin
  for (genvar i = 0; i < W; i++) begin : g_carry
    assign carry[i+1] = span_gen(gen, prop, i) | (span_prop(prop, i) & cin);
  end

  assign grp_gen  = span_gen(gen, prop, W-1);
  assign grp_prop = span_prop(prop, W-1);

endmodule

// File: rtl/alu_result_stage.sv
module alu_result_stage #(
  parameter int W = 4
) (
  input  logic [W-1:0] half,
  input  logic [W-1:0] carry_in,
  input  logic         logic_mode,
  output logic [W-1:0] res,
  output logic         all_ones
);

  // The logic mode drops the carry and inverts the half term.
  // The arithmetic mode adds the carry into the half term.
  for (genvar i = 0; i < W; i++) begin : g_res
    assign res[i] = logic_mode ? ~half[i] : (half[i] ^ carry_in[i]);
  end

  assign all_ones = &res;

endmodule

// File: rtl/fsel_alu_slice.sv
module fsel_alu_slice
  import fsel_alu_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] opa_i,
  input  logic [W-1:0] opb_i,
  input  logic [3:0]   fsel_i,
  input  logic         logic_mode_i,
  input  logic         cin_n_i,
  output logic [W-1:0] res_o,
  output logic         cout_n_o,
  output logic         grp_prop_n_o,
  output logic         grp_gen_n_o,
  output logic         all_ones_o
);

  logic [W-1:0] prop, gen, half;
  logic [W:0]   carry;
  logic         grp_prop, grp_gen;
  logic [W-1:0] res_d;
  logic         all_ones_d;

  alu_bit_terms #(.W(W)) u_terms (
    .opa  (opa_i),
    .opb  (opb_i),
    .fsel (fsel_t'(fsel_i)),
    .prop (prop),
    .gen  (gen),
    .half (half)
  );

  alu_carry_la #(.W(W)) u_cla (
    .prop     (prop),
    .gen      (gen),
    .cin      (~cin_n_i),
    .carry    (carry),
    .grp_prop (grp_prop),
    .grp_gen  (grp_gen)
  );

  alu_result_stage #(.W(W)) u_res (
    .half       (half),
    .carry_in   (carry[W-1:0]),
    .logic_mode (logic_mode_i),
    .res        (res_d),
    .all_ones   (all_ones_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_o        <= '0;
      cout_n_o     <= 1'b1;
      grp_prop_n_o <= 1'b1;
      grp_gen_n_o  <= 1'b1;
      all_ones_o   <= 1'b0;
    end else begin
      res_o        <= res_d;
      cout_n_o     <= ~carry[W];
      grp_prop_n_o <= ~grp_prop;
      grp_gen_n_o  <= ~grp_gen;
      all_ones_o   <= all_ones_d;
    end
  end

endmodule

// File: rtl/fsel_alu_slice_chk.sv
module fsel_alu_slice_chk
  import fsel_alu_pkg::*;
#(
  parameter int W = 4
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] opa_i,
  input logic [W-1:0] opb_i,
  input logic [3:0]   fsel_i,
  input logic         logic_mode_i,
  input logic         cin_n_i,
  input logic [W-1:0] res_o,
  input logic         cout_n_o,
  input logic         grp_prop_n_o,
  input logic         grp_gen_n_o,
  input logic         all_ones_o
);

  // Set once an edge without reset has loaded the outputs from the inputs
  logic primed;
  always_ff @(posedge clk) begin
    if (rst) primed <= 1'b0;
    else     primed <= 1'b1;
  end

  assert_reset_vals_R1: assert property (@(posedge clk)
    rst |=> (res_o == '0 && cout_n_o && grp_prop_n_o && grp_gen_n_o && !all_ones_o));

  assert_logic_pass_a_R2: assert property (@(posedge clk) disable iff (rst)
    (primed && $past(logic_mode_i) && $past(fsel_i) == FSEL_LOGIC_PASS_A)
      |-> res_o == $past(opa_i));

  assert_logic_ones_R2: assert property (@(posedge clk) disable iff (rst)
    (primed && $past(logic_mode_i) && $past(fsel_i) == FSEL_LOGIC_ONES)
      |-> (res_o == '1 && all_ones_o));

  assert_logic_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (primed && $past(logic_mode_i) && $past(fsel_i) == FSEL_LOGIC_ZERO)
      |-> res_o == '0);

  assert_add_sum_R4: assert property (@(posedge clk) disable iff (rst)
    (primed && !$past(logic_mode_i) && $past(fsel_i) == FSEL_ARITH_ADD)
      |-> res_o == ($past(opa_i) + $past(opb_i) + {{(W-1){1'b0}}, !$past(cin_n_i)}));

  assert_add_cout_R5: assert property (@(posedge clk) disable iff (rst)
    (primed && $past(fsel_i) == FSEL_ARITH_ADD)
      |-> cout_n_o == !(({1'b0, $past(opa_i)} + {1'b0, $past(opb_i)}
                         + {{W{1'b0}}, !$past(cin_n_i)}) >> W));

  assert_gen_forces_carry_R6: assert property (@(posedge clk) disable iff (rst)
    (primed && !grp_gen_n_o) |-> !cout_n_o);

  assert_all_ones_R7: assert property (@(posedge clk) disable iff (rst)
    all_ones_o == (&res_o));

  assert_lookahead_R8: assert property (@(posedge clk) disable iff (rst)
    primed |-> cout_n_o == (grp_gen_n_o & (grp_prop_n_o | $past(cin_n_i))));

endmodule

bind fsel_alu_slice fsel_alu_slice_chk #(.W(W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .opa_i        (opa_i),
  .opb_i        (opb_i),
  .fsel_i       (fsel_i),
  .logic_mode_i (logic_mode_i),
  .cin_n_i      (cin_n_i),
  .res_o        (res_o),
  .cout_n_o     (cout_n_o),
  .grp_prop_n_o (grp_prop_n_o),
  .grp_gen_n_o  (grp_gen_n_o),
  .all_ones_o   (all_ones_o)
);

// File: tb/fsel_alu_slice_bench.sv
module fsel_alu_slice_bench;

  localparam int W = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] a = '0, b = '0, s = '0;
  logic       m = 1'b0, cn = 1'b1;
  logic [3:0] res;
  logic       cout_n, prop_n, gen_n, all_ones;
  int         checks = 0;
  int         fails  = 0;
  bit         done   = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  fsel_alu_slice #(.W(W)) u_fsel_alu_slice (
    .clk          (clk),
    .rst          (rst),
    .opa_i        (a),
    .opb_i        (b),
    .fsel_i       (s),
    .logic_mode_i (m),
    .cin_n_i      (cn),
    .res_o        (res),
    .cout_n_o     (cout_n),
    .grp_prop_n_o (prop_n),
    .grp_gen_n_o  (gen_n),
    .all_ones_o   (all_ones)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d (a=%0d b=%0d s=%b m=%0b cn=%0b)",
               req, what, act, exp, a, b, s, m, cn);
    end
  endtask

  // Drive at a falling edge; the next falling edge follows one capture edge
  task automatic apply(input logic [3:0] ia, ib, is, input logic im, icn);
    @(negedge clk);
    a = ia; b = ib; s = is; m = im; cn = icn;
    @(negedge clk);
  endtask

  // Reference tables, written from the function list
  function automatic logic [3:0] ref_logic(input logic [3:0] fs, fa, fb);
    case (fs)
      4'h0: return ~fa;        4'h1: return ~(fa | fb);
      4'h2: return ~fa & fb;   4'h3: return 4'h0;
      4'h4: return ~(fa & fb); 4'h5: return ~fb;
      4'h6: return fa ^ fb;    4'h7: return fa & ~fb;
      4'h8: return ~fa | fb;   4'h9: return ~(fa ^ fb);
      4'hA: return fb;         4'hB: return fa & fb;
      4'hC: return 4'hF;       4'hD: return fa | ~fb;
      4'hE: return fa | fb;    default: return fa;
    endcase
  endfunction

  // The two addends {x, y} of each arithmetic function ("minus 1" is + 1111)
  function automatic logic [7:0] ref_addends(input logic [3:0] fs, fa, fb);
    case (fs)
      4'h0: return {fa, 4'h0};        4'h1: return {fa | fb, 4'h0};
      4'h2: return {fa | ~fb, 4'h0};  4'h3: return {4'h0, 4'hF};
      4'h4: return {fa, fa & ~fb};    4'h5: return {fa | fb, fa & ~fb};
      4'h6: return {fa, ~fb};         4'h7: return {fa & ~fb, 4'hF};
      4'h8: return {fa, fa & fb};     4'h9: return {fa, fb};
      4'hA: return {fa | ~fb, fa & fb}; 4'hB: return {fa & fb, 4'hF};
      4'hC: return {fa, fa};          4'hD: return {fa | fb, fa};
      4'hE: return {fa | ~fb, fa};    default: return {fa, 4'hF};
    endcase
  endfunction

  task automatic check_all();
    logic [7:0] xy;
    logic [4:0] sum5, raw5;
    logic [3:0] exp_res;
    logic       exp_prop_n;
    xy   = ref_addends(s, a, b);
    raw5 = {1'b0, xy[7:4]} + {1'b0, xy[3:0]};
    sum5 = raw5 + {4'b0, ~cn};
    exp_res    = m ? ref_logic(s, a, b) : sum5[3:0];
    exp_prop_n = !(&(a | (b & {4{s[0]}}) | (~b & {4{s[1]}})));
    check(m ? "R2" : "R4", "result", res, exp_res);
    check("R5", "cout_n", cout_n, !sum5[4]);
    check("R6", "grp_gen_n", gen_n, !raw5[4]);
    check("R6", "grp_prop_n", prop_n, exp_prop_n);
    check("R7", "all_ones", all_ones, &exp_res);
    check("R8", "lookahead", cout_n, gen_n & (prop_n | cn));
  endtask

  task automatic t_reset_latency();
    @(negedge clk);
    rst = 1'b1; a = 4'hF; b = 4'hF; s = 4'hC; m = 1'b1; cn = 1'b0;
    @(negedge clk);
    check("R1", "reset res", res, 0);
    check("R1", "reset cout_n", cout_n, 1);
    check("R1", "reset prop_n", prop_n, 1);
    check("R1", "reset gen_n", gen_n, 1);
    check("R1", "reset all_ones", all_ones, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1", "first result", res, 15);
    a = 4'h3; s = 4'hF;          // pass A; output must hold until the edge
    #1 check("R1", "held before edge", res, 15);
    @(negedge clk);
    check("R1", "after edge", res, 3);
  endtask

  task automatic t_logic_named();
    apply(4'h5, 4'h9, 4'b0011, 1, 1); check("R2", "zero", res, 0);
    apply(4'h5, 4'h9, 4'b1100, 1, 1); check("R2", "ones", res, 15);
    apply(4'h5, 4'h9, 4'b1111, 1, 0); check("R2", "pass A", res, 5);
    apply(4'h5, 4'h9, 4'b1010, 1, 0); check("R2", "pass B", res, 9);
    apply(4'h6, 4'hA, 4'b0110, 1, 1); check("R2", "xor", res, 12);
    apply(4'h6, 4'hA, 4'b1001, 1, 1); check("R2", "xnor", res, 3);
  endtask

  task automatic t_mode_isolation();
    logic [3:0] r1;
    logic       c1, p1, g1;
    for (int k = 0; k < 16; k++) begin
      apply(4'hB, 4'h6, 4'(k), 1, 1); r1 = res;
      apply(4'hB, 4'h6, 4'(k), 1, 0);
      check("R3", "cin ignored in logic mode", res, r1);
      c1 = cout_n; p1 = prop_n; g1 = gen_n;
      apply(4'hB, 4'h6, 4'(k), 0, 0);
      check("R3", "mode vs cout_n", cout_n, c1);
      check("R3", "mode vs prop_n", prop_n, p1);
      check("R3", "mode vs gen_n", gen_n, g1);
    end
  endtask

  task automatic t_arith_named();
    apply(4'h7, 4'h9, 4'b1001, 0, 1);
    check("R4", "7+9", res, 0); check("R5", "7+9 carry", cout_n, 0);
    apply(4'h9, 4'h3, 4'b0110, 0, 1); check("R4", "9-3-1", res, 5);
    apply(4'h9, 4'h3, 4'b0110, 0, 0); check("R4", "9-3", res, 6);
    apply(4'hD, 4'h2, 4'b0000, 0, 1); check("R4", "pass A", res, 13);
    apply(4'h0, 4'h2, 4'b1111, 0, 1);
    check("R4", "0-1", res, 15); check("R5", "0-1 no carry", cout_n, 1);
    apply(4'hB, 4'h0, 4'b1100, 0, 1);
    check("R4", "double", res, 6); check("R5", "double carry", cout_n, 0);
  endtask

  task automatic t_group_terms();
    apply(4'hF, 4'h0, 4'b1001, 0, 1);
    check("R6", "prop_n all", prop_n, 0); check("R6", "gen_n none", gen_n, 1);
    check("R5", "no carry in", cout_n, 1);
    apply(4'hF, 4'h0, 4'b1001, 0, 0);
    check("R6", "prop_n cin0", prop_n, 0); check("R6", "gen_n cin0", gen_n, 1);
    check("R8", "propagated carry", cout_n, 0);
    apply(4'h8, 4'h8, 4'b1001, 0, 1);
    check("R6", "gen_n generate", gen_n, 0); check("R5", "generated carry", cout_n, 0);
  endtask

  task automatic t_equality();
    apply(4'hA, 4'hA, 4'b0110, 0, 1);
    check("R7", "equal", all_ones, 1); check("R7", "equal cout_n", cout_n, 1);
    apply(4'hA, 4'h4, 4'b0110, 0, 1);
    check("R7", "A>B", all_ones, 0); check("R7", "A>B cout_n", cout_n, 0);
    apply(4'h4, 4'hA, 4'b0110, 0, 1);
    check("R7", "A<B", all_ones, 0); check("R7", "A<B cout_n", cout_n, 1);
  endtask

  task automatic cascade(input logic [7:0] xa, xb, input logic [3:0] fs,
                         input logic cn0, input logic [8:0] exp9);
    logic [3:0] lo;
    logic       mid;
    apply(xa[3:0], xb[3:0], fs, 0, cn0); lo = res; mid = cout_n;
    apply(xa[7:4], xb[7:4], fs, 0, mid);
    check("R9", "cascade result", {res, lo}, exp9[7:0]);
    check("R9", "cascade cout_n", cout_n, !exp9[8]);
  endtask

  task automatic t_cascade();
    cascade(8'hFF, 8'h01, 4'b1001, 1, 9'h100);
    cascade(8'h8F, 8'h71, 4'b1001, 1, 9'h100);
    cascade(8'h3C, 8'h25, 4'b1001, 1, 9'h061);
    cascade(8'h3C, 8'h25, 4'b1001, 0, 9'h062);
    // A minus B with carry in asserted; carry out set when no borrow
    cascade(8'h50, 8'h21, 4'b0110, 0, 9'h12F);
    cascade(8'h21, 8'h50, 4'b0110, 0, 9'h0D1);
  endtask

  task automatic t_exhaustive();
    for (int i = 0; i < 16384; i++) begin
      logic [13:0] v;
      v = 14'(i);
      apply(v[13:10], v[9:6], v[5:2], v[1], v[0]);
      check_all();
    end
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    t_reset_latency();
    t_logic_named();
    t_mode_isolation();
    t_arith_named();
    t_group_terms();
    t_equality();
    t_cascade();
    t_exhaustive();
    done = 1'b1;
    report();
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      report();
    end
  end

endmodule